// File: doc/BRIEF.md
# Serial Port FIFO Status and Interrupt Unit

This block sits between a register interface and a synchronous serial shift engine. Words written by software go into an eight-entry transmit queue. The engine receives them one at a time through a load request. Each completed frame the engine reports is stored in an eight-entry receive queue, and software pops it through a data read. The serial shifting and the bit-clock division are not part of this block. The engine is represented by a load request and load data on the output side, and by a frame-done strobe with frame data and a one-per-bit tick on the input side.

The unit produces five status flags from the queue fill levels and the engine state. It also runs a four-source interrupt controller. Two sources are level conditions on the queues: the transmit queue having half or more of its slots free, and the receive queue being half or more occupied. The other two are sticky events. One is a frame arriving while the receive queue is full. The other is a receive timeout: unread data sitting in the receive queue with no reads and no new arrivals for 32 bit periods. Software sees a raw view of the four sources and a masked view, and a single interrupt line. It can set the mask, and it can clear the two sticky events.

Top module: `ssp_irq_fifo`

## Requirements
- R1: After reset, busy, rx_full and rx_not_empty are 0, tx_not_full and tx_empty are 1, raw_status is 4'b1000, masked_status is 0, irq is 0 and rd_data is 0.
- R2: load_req is high exactly when no frame is in flight and the transmit queue holds a word. load_data then shows the oldest written word, and that word is removed at the same clock edge. The next load waits for frame_done.
- R3: A data write while the transmit queue holds 8 words is dropped and does not change the queue.
- R4: rd_data shows the oldest received frame. A read removes it. Frames come out in arrival order, and rd_data is 0 while the receive queue is empty.
- R5: raw_status bit 3 (transmit level) is 1 exactly when 4 or more transmit slots are free.
- R6: raw_status bit 2 (receive level) is 1 exactly when 4 or more receive entries are filled.
- R7: A frame_done while the receive queue holds 8 entries sets raw_status bit 0 (overrun), which stays set until cleared. That frame is discarded and the stored entries are unchanged.
- R8: raw_status bit 1 (timeout) is set on the 32nd bit_tick counted while the receive queue is non-empty. The count restarts on any receive read or frame_done, and is cleared while the queue is empty. The bit stays set until cleared.
- R9: A clear write with clr_wdata bit 0 set clears the overrun bit, and with bit 1 set clears the timeout bit. The level bits 2 and 3 are not affected by clear writes. A new event in the same cycle wins over the clear.
- R10: masked_status equals raw_status ANDed with the last mask write (reset value 0). irq is the OR of masked_status.
- R11: busy is 1 while the transmit queue is non-empty or a frame is in flight. tx_not_full is low at 8 stored words. rx_full is high at 8 entries and rx_not_empty at one or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data_en | input | 1 | Data register write strobe (push transmit word) |
| wr_data | input | 16 | Word to transmit |
| rd_data_en | input | 1 | Data register read strobe (pop receive entry) |
| rd_data | output | 16 | Oldest received frame, 0 when empty |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wdata | input | 4 | New interrupt mask, same bit layout as raw_status |
| clr_wr_en | input | 1 | Clear register write strobe |
| clr_wdata | input | 2 | Bit 0 clears overrun, bit 1 clears timeout |
| raw_status | output | 4 | Raw sources: bit 0 overrun, 1 timeout, 2 receive level, 3 transmit level |
| masked_status | output | 4 | raw_status AND mask |
| irq | output | 1 | OR of masked_status |
| busy | output | 1 | Transmit data pending or frame in flight |
| rx_full | output | 1 | Receive queue full |
| rx_not_empty | output | 1 | Receive queue holds data |
| tx_not_full | output | 1 | Transmit queue can take a word |
| tx_empty | output | 1 | Transmit queue empty |
| load_req | output | 1 | Engine load request; word is taken this cycle |
| load_data | output | 16 | Word handed to the engine |
| frame_done | input | 1 | Engine finished a frame |
| frame_data | input | 16 | Received frame word |
| bit_tick | input | 1 | One pulse per serial bit period |

## Verification
The hardest state to reach is the receive overrun. It needs eight frames already stored, plus a ninth frame from an engine that is still busy with transmit data. The bench reaches it with one burst of ten writes, which overflows the transmit queue by one word. It then completes nine frames in turn, so the last completion lands on a full receive queue. It then drains the receive queue and compares each word, to show that the dropped frame left no trace. The timeout is approached tick by tick. The bench checks that the bit is still clear after 31 ticks and set after 32. It then shows that a frame arriving mid-count pushes expiry past 32 ticks in total.

// File: rtl/ssp_irq_pkg.sv
// Package: shared bit positions of the four interrupt sources.
// Assumes every user indexes raw/masked/mask vectors with these constants.
package ssp_irq_pkg;
    localparam int NUM_IRQ = 4;
    localparam int IRQ_OVR = 0;  // receive overrun (sticky)
    localparam int IRQ_TMO = 1;  // receive timeout (sticky)
    localparam int IRQ_RXL = 2;  // receive level (half full)
    localparam int IRQ_TXL = 3;  // transmit level (half empty)
    localparam int CLR_W   = 2;  // clear register covers the sticky sources only
endpackage

// File: rtl/ssp_fifo.sv
// Module: ssp_fifo
// Synchronous first-in first-out queue with a fill counter.
// Assumes: a push while full is dropped, a pop while empty is dropped,
// and fullness is judged on the state before this cycle's pop.
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr, wr_next, rd_next;
    logic             do_push, do_pop;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Pointer advance: natural wrap for power-of-two depth, compare otherwise.
    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_next = wr_ptr + 1'b1;
            assign rd_next = rd_ptr + 1'b1;
        end else begin : g_any
            assign wr_next = (wr_ptr == LAST_C) ? '0 : wr_ptr + 1'b1;
            assign rd_next = (rd_ptr == LAST_C) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointers and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_next;
            if (do_pop)  rd_ptr <= rd_next;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/ssp_rx_timeout.sv
// Module: ssp_rx_timeout
// Counts bit ticks while the receive queue holds data and pulses expire
// on the LIMIT-th tick. Assumes restart (read or arrival) has priority over
// a tick in the same cycle. The counter saturates so expiry fires only once.
module ssp_rx_timeout #(
    parameter int LIMIT = 32,
    localparam int TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic restart,
    input  logic bit_tick,
    output logic expire
);
    localparam logic [TW-1:0] LAST_C  = TW'(LIMIT - 1);
    localparam logic [TW-1:0] LIMIT_C = TW'(LIMIT);

    logic [TW-1:0] cnt;

    assign expire = armed && !restart && bit_tick && (cnt == LAST_C);

    // Idle-period counter with restart and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (!armed || restart)       cnt <= '0;
        else if (bit_tick && cnt < LIMIT_C) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ssp_irq_ctrl.sv
// Module: ssp_irq_ctrl
// Holds the mask register and the two sticky event bits, and forms the raw
// and masked views and the combined interrupt. Assumes level inputs are
// already derived from queue counts. A set event wins over a clear.
module ssp_irq_ctrl
    import ssp_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_level,
    input  logic               rx_level,
    input  logic               ovr_evt,
    input  logic               tmo_evt,
    input  logic               mask_wr_en,
    input  logic [NUM_IRQ-1:0] mask_wdata,
    input  logic               clr_wr_en,
    input  logic [CLR_W-1:0]   clr_wdata,
    output logic [NUM_IRQ-1:0] raw,
    output logic [NUM_IRQ-1:0] masked,
    output logic               irq
);
    logic [NUM_IRQ-1:0] mask_q;
    logic               ovr_q, tmo_q;

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= '0;
        else if (mask_wr_en) mask_q <= mask_wdata;
    end

    // Sticky overrun and timeout bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            tmo_q <= 1'b0;
        end else begin
            if (ovr_evt)                                ovr_q <= 1'b1;
            else if (clr_wr_en && clr_wdata[IRQ_OVR])   ovr_q <= 1'b0;
            if (tmo_evt)                                tmo_q <= 1'b1;
            else if (clr_wr_en && clr_wdata[IRQ_TMO])   tmo_q <= 1'b0;
        end
    end

    // Raw view assembly.
    always_comb begin
        raw          = '0;
        raw[IRQ_OVR] = ovr_q;
        raw[IRQ_TMO] = tmo_q;
        raw[IRQ_RXL] = rx_level;
        raw[IRQ_TXL] = tx_level;
    end

    assign masked = raw & mask_q;
    assign irq    = |masked;
endmodule

// File: rtl/ssp_irq_fifo.sv
// Module: ssp_irq_fifo (top)
// Transmit and receive queues around an external shift engine, status flags
// and a four-source interrupt controller. Assumes the engine takes a word
// whenever load_req is high, and signals each finished frame with a
// one-cycle frame_done. An overrun frame is discarded. A frame_done with no
// frame in flight is still stored as received data.
module ssp_irq_fifo
    import ssp_irq_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int FIFO_DEPTH   = 8,
    parameter int TIMEOUT_BITS = 32,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_data_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_data_en,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               mask_wr_en,
    input  logic [NUM_IRQ-1:0] mask_wdata,
    input  logic               clr_wr_en,
    input  logic [CLR_W-1:0]   clr_wdata,
    output logic [NUM_IRQ-1:0] raw_status,
    output logic [NUM_IRQ-1:0] masked_status,
    output logic               irq,
    output logic               busy,
    output logic               rx_full,
    output logic               rx_not_empty,
    output logic               tx_not_full,
    output logic               tx_empty,
    output logic               load_req,
    output logic [DATA_W-1:0]  load_data,
    input  logic               frame_done,
    input  logic [DATA_W-1:0]  frame_data,
    input  logic               bit_tick
);
    localparam logic [CW-1:0] DEPTH_C = CW'(FIFO_DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(FIFO_DEPTH / 2);

    logic [CW-1:0]     tx_count, rx_count;
    logic              tx_full_w, tx_empty_w, rx_full_w, rx_empty_w;
    logic [DATA_W-1:0] rx_head;
    logic              in_flight;
    logic              rx_pop, tmo_evt, ovr_evt;

    assign load_req = !in_flight && !tx_empty_w;
    assign rx_pop   = rd_data_en && !rx_empty_w;
    assign ovr_evt  = frame_done && rx_full_w;

    ssp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_data_en),
        .push_data (wr_data),
        .pop       (load_req),
        .head      (load_data),
        .count     (tx_count),
        .full      (tx_full_w),
        .empty     (tx_empty_w)
    );

    ssp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (frame_done),
        .push_data (frame_data),
        .pop       (rd_data_en),
        .head      (rx_head),
        .count     (rx_count),
        .full      (rx_full_w),
        .empty     (rx_empty_w)
    );

    ssp_rx_timeout #(.LIMIT(TIMEOUT_BITS)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (!rx_empty_w),
        .restart  (rx_pop || frame_done),
        .bit_tick (bit_tick),
        .expire   (tmo_evt)
    );

    ssp_irq_ctrl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_level   ((DEPTH_C - tx_count) >= HALF_C),
        .rx_level   (rx_count >= HALF_C),
        .ovr_evt    (ovr_evt),
        .tmo_evt    (tmo_evt),
        .mask_wr_en (mask_wr_en),
        .mask_wdata (mask_wdata),
        .clr_wr_en  (clr_wr_en),
        .clr_wdata  (clr_wdata),
        .raw        (raw_status),
        .masked     (masked_status),
        .irq        (irq)
    );

    // Engine occupancy: set when a word is handed over, cleared on frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)          in_flight <= 1'b0;
        else if (load_req)   in_flight <= 1'b1;
        else if (frame_done) in_flight <= 1'b0;
    end

    assign rd_data      = rx_empty_w ? '0 : rx_head;
    assign busy         = in_flight || !tx_empty_w;
    assign rx_full      = rx_full_w;
    assign rx_not_empty = !rx_empty_w;
    assign tx_not_full  = !tx_full_w;
    assign tx_empty     = tx_empty_w;
endmodule

// File: rtl/ssp_irq_fifo_chk.sv
// Module: ssp_irq_fifo_chk
// Temporal checks on the top-level ports, bound into every ssp_irq_fifo.
module ssp_irq_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_data_en,
    input logic       rd_data_en,
    input logic       clr_wr_en,
    input logic [1:0] clr_wdata,
    input logic [3:0] raw_status,
    input logic [3:0] masked_status,
    input logic       irq,
    input logic       busy,
    input logic       rx_full,
    input logic       rx_not_empty,
    input logic       tx_not_full,
    input logic       load_req,
    input logic       frame_done
);
    // R7
    overrun_keeps_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && rx_full && !rd_data_en |=> rx_full && raw_status[0]);

    // R9
    clear_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_en && clr_wdata[0] && !(frame_done && rx_full) |=> !raw_status[0]);

    // R3
    tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_not_full && wr_data_en && !load_req |=> !tx_not_full);

    // R8
    timeout_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_status[1]) |-> $past(rx_not_empty));

    // R10
    masked_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked_status & ~raw_status) == 4'b0) && (irq == (masked_status != 4'b0)));

    // R11
    busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> busy);
endmodule

bind ssp_irq_fifo ssp_irq_fifo_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_data_en    (wr_data_en),
    .rd_data_en    (rd_data_en),
    .clr_wr_en     (clr_wr_en),
    .clr_wdata     (clr_wdata),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq           (irq),
    .busy          (busy),
    .rx_full       (rx_full),
    .rx_not_empty  (rx_not_empty),
    .tx_not_full   (tx_not_full),
    .load_req      (load_req),
    .frame_done    (frame_done)
);

// File: tb/ssp_irq_fifo_test.sv
module ssp_irq_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_data_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_data_en = 1'b0;
    logic [15:0] rd_data;
    logic        mask_wr_en = 1'b0;
    logic [3:0]  mask_wdata = '0;
    logic        clr_wr_en = 1'b0;
    logic [1:0]  clr_wdata = '0;
    logic [3:0]  raw_status, masked_status;
    logic        irq, busy, rx_full, rx_not_empty, tx_not_full, tx_empty;
    logic        load_req;
    logic [15:0] load_data;
    logic        frame_done = 1'b0;
    logic [15:0] frame_data = '0;
    logic        bit_tick = 1'b0;

    int total = 0;
    int fails = 0;
    logic [15:0] loads [16];
    int n_loads = 0;

    always #2.5 clk = ~clk;

    ssp_irq_fifo uut (.*);

    // Record every word handed to the engine (sampled away from the edge).
    always @(negedge clk) begin
        if (rst_n && load_req && n_loads < 16) begin
            loads[n_loads] = load_data;
            n_loads++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] d);
        @(negedge clk); wr_data_en = 1'b1; wr_data = d;
        @(negedge clk); wr_data_en = 1'b0;
    endtask

    task automatic finish_frame(input logic [15:0] d);
        @(negedge clk); frame_done = 1'b1; frame_data = d;
        @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
    endtask

    task automatic set_mask(input logic [3:0] m);
        @(negedge clk); mask_wr_en = 1'b1; mask_wdata = m;
        @(negedge clk); mask_wr_en = 1'b0;
    endtask

    task automatic clear(input logic [1:0] c);
        @(negedge clk); clr_wr_en = 1'b1; clr_wdata = c;
        @(negedge clk); clr_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 busy", busy, 0);
        check("R1 rx_full", rx_full, 0);
        check("R1 rx_not_empty", rx_not_empty, 0);
        check("R1 tx_not_full", tx_not_full, 1);
        check("R1 tx_empty", tx_empty, 1);
        check("R1 raw", raw_status, 4'b1000);
        check("R1 masked", masked_status, 0);
        check("R1 irq", irq, 0);
        check("R1 rd_data", rd_data, 0);
    endtask

    // Ten back-to-back writes: one goes to the engine, eight queue, one drops.
    task automatic t_tx_fill_drain();
        @(negedge clk); wr_data_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            wr_data = 16'hA000 + 16'(i);
            @(negedge clk);
        end
        wr_data_en = 1'b0;
        #1;
        check("R11 tx_not_full low when full", tx_not_full, 0);
        check("R11 busy", busy, 1);
        check("R5 tx level at 8 stored", raw_status[3], 0);
        check("R2 single load while in flight", n_loads, 1);
        for (int k = 1; k <= 8; k++) begin
            finish_frame(16'h5000 + 16'(k));
            @(negedge clk);
            #1;
            if (k == 3) check("R5 tx level with 5 stored", raw_status[3], 0);
            if (k == 4) check("R5 tx level with 4 stored", raw_status[3], 1);
        end
        check("R3 dropped write left queue empty", tx_empty, 1);
        check("R2 load count", n_loads, 9);
        for (int i = 0; i < 9 && i < n_loads; i++)
            check("R2 load order", loads[i], 16'hA000 + 16'(i));
    endtask

    // Receive queue now holds 8 frames; the ninth overruns.
    task automatic t_rx_overrun_drain();
        check("R11 rx_full", rx_full, 1);
        check("R6 rx level at 8", raw_status[2], 1);
        check("R7 no overrun yet", raw_status[0], 0);
        finish_frame(16'h5009);
        #1;
        check("R7 overrun set", raw_status[0], 1);
        check("R7 still full", rx_full, 1);
        check("R11 busy cleared", busy, 0);
        for (int j = 0; j < 8; j++) begin
            @(negedge clk); #1;
            check("R4 rx order", rd_data, 16'h5001 + 16'(j));
            if (j == 4) check("R6 rx level with 4", raw_status[2], 1);
            if (j == 5) check("R6 rx level with 3", raw_status[2], 0);
            rd_data_en = 1'b1;
            @(negedge clk); rd_data_en = 1'b0;
        end
        #1;
        check("R4 empty read zero", rd_data, 0);
        check("R11 rx_not_empty", rx_not_empty, 0);
        check("R7 overrun sticky", raw_status[0], 1);
    endtask

    task automatic t_mask_clear();
        set_mask(4'b0001); #1;
        check("R10 masked overrun", masked_status, 4'b0001);
        check("R10 irq on", irq, 1);
        set_mask(4'b0010); #1;
        check("R10 masked none", masked_status, 0);
        check("R10 irq off", irq, 0);
        set_mask(4'b1000); #1;
        check("R10 masked tx level", masked_status, 4'b1000);
        clear(2'b10); #1;
        check("R9 timeout clear keeps overrun", raw_status, 4'b1001);
        clear(2'b11); #1;
        check("R9 clear overrun, level bit kept", raw_status, 4'b1000);
        check("R10 irq from level", irq, 1);
    endtask

    task automatic t_timeout();
        set_mask(4'b0010);
        finish_frame(16'h7777);
        for (int i = 0; i < 31; i++) tick();
        #1;
        check("R8 no timeout after 31", raw_status[1], 0);
        tick(); #1;
        check("R8 timeout after 32", raw_status[1], 1);
        check("R10 irq timeout", irq, 1);
        clear(2'b10); #1;
        check("R9 timeout cleared", raw_status[1], 0);
        @(negedge clk); rd_data_en = 1'b1;
        @(negedge clk); rd_data_en = 1'b0;
        finish_frame(16'h1111);
        for (int i = 0; i < 20; i++) tick();
        finish_frame(16'h2222);
        for (int i = 0; i < 20; i++) tick();
        #1;
        check("R8 restart on arrival", raw_status[1], 0);
        for (int i = 0; i < 12; i++) tick();
        #1;
        check("R8 timeout after restart", raw_status[1], 1);
    endtask

    initial begin
        #100us;
        fails++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_fill_drain();
        t_rx_overrun_drain();
        t_mask_clear();
        t_timeout();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule